// File: doc/BRIEF.md
# Two-Wire ADC Polling Master

This block is a two-wire bus master that reads 12-bit conversion results from an analog-to-digital converter target. A host sets a mode (single or continuous), a conversion count and a bit-rate divider, then pulses a start input. The controller runs a fixed read-only sequence. It sends a STOP to put the bus in a known state, then a START and the read address. It then clocks in one high/low byte pair for each conversion.

The master acknowledges every high byte. After each low byte it sends an ACK to keep the target streaming, or a NACK to end the read before the closing STOP. Each completed pair becomes a 12-bit result with a one-cycle valid strobe, and the raw bytes are also kept in their own registers. If the target does not acknowledge its address, a sticky error flag is set and the transfer is closed at once.

SCL is driven push-pull. SDA is driven through an active-high pull-low enable, so the pad is open-drain.

Top module: `adc_poll_master`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `scl_o`=1, `sda_oe_o`=0 and `result_valid_o`=0. Reset also clears `ack_err_o`.
- R2: Every transaction makes exactly two STOP conditions: one before a single START, and one at the end. After the START comes the address byte 8'h9B, sent MSB first: device code 1001, address 101, and read bit 1.
- R3: Each SCL low interval lasts 2*(`div_i`+1) clock cycles, so one bit takes 4*(`div_i`+1) cycles. SDA changes while SCL is high only to form a START or a STOP.
- R4: Read bits are sampled at the clock edge where SCL rises. The master drives an ACK (SDA low) in the ninth bit after each high byte.
- R5: With `cont_mode_i`=0 the master reads exactly one conversion, sends a NACK (SDA released) after its low byte, and then a STOP.
- R6: With `cont_mode_i`=1 the master reads `conv_count_i` conversions, where 0 means 3. It ACKs every low byte except the last one, which gets a NACK and then a STOP.
- R7: For each conversion, `result_o`={high[3:0], low[7:0]}, `high_byte_o` and `low_byte_o` hold the received bytes, and `result_valid_o` is high for exactly one cycle while `busy_o` is high.
- R8: If SDA is high when the target's address acknowledge is sampled, `ack_err_o` is set, no data byte is read and a STOP follows. `ack_err_o` then stays set until reset.
- R9: `busy_o` goes high on the cycle after a `start_i` pulse taken while idle, and stays high until the final STOP ends. `start_i` has no effect while `busy_o` is high.
- R10: The package divider function gives (fclk/rate)/4-1: 11 for a 20 MHz clock at 400 kHz, and 49 at 100 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| cont_mode_i | input | 1 | 0 single conversion, 1 continuous |
| conv_count_i | input | CNT_W | Conversions in continuous mode, 0 means 3 |
| div_i | input | DIV_W | Quarter-bit divider value |
| sda_i | input | 1 | SDA line level |
| scl_o | output | 1 | SCL output |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Transaction in progress |
| result_o | output | 12 | Assembled conversion result |
| high_byte_o | output | 8 | Last received high byte |
| low_byte_o | output | 8 | Last received low byte |
| result_valid_o | output | 1 | One-cycle strobe per conversion |
| ack_err_o | output | 1 | Sticky address acknowledge error |

## Verification
The assertions check on every cycle that:
- the lines sit released with the clock high while the block is idle;
- SDA changes during a high SCL only inside the STOP and START sequences;
- the valid strobe is a single-cycle pulse inside a transaction;
- the error flag never clears;
- busy rises only after a start request.

The bench alone can show the order of bus conditions, the address bits and the per-bit SCL timing. It also shows that the ACK/NACK pattern tracks the mode and count, and that results match the bytes a behavioural target sends. It sweeps several divider values, both modes and every count from 0 to 4, plus an absent target and a start request given during a transfer.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRESTOP,
    ST_START,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RD_HI,
    ST_HI_ACK,
    ST_RD_LO,
    ST_LO_ACK,
    ST_STOP
  } seq_state_e;

  // device code 1001, address 101, read
  localparam logic [7:0] TGT_ADDR_RD = 8'h9B;

  function automatic int calc_divider(int fclk_hz, int rate_hz);
    return (fclk_hz / rate_hz) / 4 - 1;
  endfunction

endpackage

// File: rtl/aqm_tick_gen.sv
module aqm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = wrap && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/aqm_seq.sv
module aqm_seq
  import adc_poll_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int DEF_CONV = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_mode_i,
  input  logic [CNT_W-1:0] conv_count_i,
  input  logic             tick_i,
  input  logic             sda_i,
  output logic             clr_tick_o,
  output logic             scl_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output seq_state_e       state_o,
  output logic             shift_o,
  output logic             hi_done_o,
  output logic             lo_done_o,
  output logic             ack_err_o
);

  localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(DEF_CONV);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic [1:0]       phase_q, phase_d;
  logic [2:0]       bit_q, bit_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             scl_q, oe_q, ack_bad_q, ack_err_q;
  logic             scl_d, oe_d, keep_d;
  logic             start_go, upd, sample_now, rx_bit;

  assign busy_o     = (state_q != ST_IDLE);
  assign start_go   = !busy_o && start_i;
  assign clr_tick_o = start_go;
  assign upd        = start_go || (tick_i && busy_o);
  // SCL rises on this edge
  assign sample_now = tick_i && (phase_q == 2'd1);
  assign rx_bit     = (state_q == ST_RD_HI) || (state_q == ST_RD_LO);

  assign shift_o   = sample_now && rx_bit;
  assign hi_done_o = shift_o && (state_q == ST_RD_HI) && (bit_q == 3'd0);
  assign lo_done_o = shift_o && (state_q == ST_RD_LO) && (bit_q == 3'd0);

  assign scl_o     = scl_q;
  assign sda_oe_o  = oe_q;
  assign ack_err_o = ack_err_q;
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    left_d  = left_q;
    if (start_go) begin
      state_d = ST_PRESTOP;
      phase_d = 2'd0;
      bit_d   = 3'd7;
      if (!cont_mode_i)              left_d = ONE_CNT;
      else if (conv_count_i == '0)   left_d = DEF_CNT;
      else                           left_d = conv_count_i;
    end else if (tick_i && busy_o) begin
      phase_d = phase_q + 2'd1;
      if (phase_q == 2'd3) begin
        unique case (state_q)
          ST_PRESTOP: state_d = ST_START;
          ST_START: begin
            state_d = ST_ADDR;
            bit_d   = 3'd7;
          end
          ST_ADDR: begin
            if (bit_q == 3'd0) state_d = ST_ADDR_ACK;
            else               bit_d   = bit_q - 3'd1;
          end
          ST_ADDR_ACK: begin
            if (ack_bad_q) state_d = ST_STOP;
            else begin
              state_d = ST_RD_HI;
              bit_d   = 3'd7;
            end
          end
          ST_RD_HI: begin
            if (bit_q == 3'd0) state_d = ST_HI_ACK;
            else               bit_d   = bit_q - 3'd1;
          end
          ST_HI_ACK: begin
            state_d = ST_RD_LO;
            bit_d   = 3'd7;
          end
          ST_RD_LO: begin
            if (bit_q == 3'd0) state_d = ST_LO_ACK;
            else               bit_d   = bit_q - 3'd1;
          end
          ST_LO_ACK: begin
            if (left_q > ONE_CNT) begin
              state_d = ST_RD_HI;
              bit_d   = 3'd7;
              left_d  = left_q - ONE_CNT;
            end else begin
              state_d = ST_STOP;
            end
          end
          ST_STOP: state_d = ST_IDLE;
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  // line levels for the next (state, phase); phase 0 holds SDA while SCL falls
  always_comb begin
    scl_d  = (phase_d >= 2'd2);
    oe_d   = 1'b0;
    keep_d = (phase_d == 2'd0);
    unique case (state_d)
      ST_IDLE: begin
        scl_d  = 1'b1;
        keep_d = 1'b0;
      end
      ST_PRESTOP, ST_STOP: oe_d = (phase_d == 2'd1) || (phase_d == 2'd2);
      ST_START: begin
        scl_d  = 1'b1;
        oe_d   = (phase_d >= 2'd2);
        keep_d = 1'b0;
      end
      ST_ADDR:    oe_d = !TGT_ADDR_RD[bit_d];
      ST_HI_ACK:  oe_d = 1'b1;
      ST_LO_ACK:  oe_d = (left_d > ONE_CNT);
      default:    oe_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= '0;
      bit_q     <= '0;
      left_q    <= '0;
      scl_q     <= 1'b1;
      oe_q      <= 1'b0;
      ack_bad_q <= 1'b0;
      ack_err_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      left_q  <= left_d;
      if (upd) begin
        scl_q <= scl_d;
        if (!keep_d) oe_q <= oe_d;
      end
      if (sample_now && state_q == ST_ADDR_ACK) begin
        ack_bad_q <= sda_i;
        if (sda_i) ack_err_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/aqm_rx_assemble.sv
module aqm_rx_assemble #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             hi_done_i,
  input  logic             lo_done_i,
  input  logic             bit_i,
  output logic [7:0]       hi_o,
  output logic [7:0]       lo_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);

  localparam int HI_W = RES_W - 8;

  logic [6:0]       sr_q;
  logic [7:0]       byte_d;
  logic [7:0]       hi_q, lo_q;
  logic [RES_W-1:0] res_q;
  logic             valid_q;

  assign byte_d = {sr_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= lo_done_i;
      if (shift_i)   sr_q <= byte_d[6:0];
      if (hi_done_i) hi_q <= byte_d;
      if (lo_done_i) begin
        lo_q  <= byte_d;
        res_q <= {hi_q[HI_W-1:0], byte_d};
      end
    end
  end

  assign hi_o     = hi_q;
  assign lo_o     = lo_q;
  assign result_o = res_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/adc_poll_master.sv
module adc_poll_master
  import adc_poll_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int DEF_CONV = 3,
  parameter int DIV_W    = 8,
  parameter int RES_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_mode_i,
  input  logic [CNT_W-1:0] conv_count_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o,
  output logic [7:0]       high_byte_o,
  output logic [7:0]       low_byte_o,
  output logic             result_valid_o,
  output logic             ack_err_o
);

  logic       tick, clr_tick, shift, hi_done, lo_done;
  seq_state_e state_w;

  aqm_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_tick),
    .div_i  (div_i),
    .tick_o (tick)
  );

  aqm_seq #(.CNT_W(CNT_W), .DEF_CONV(DEF_CONV)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .cont_mode_i  (cont_mode_i),
    .conv_count_i (conv_count_i),
    .tick_i       (tick),
    .sda_i        (sda_i),
    .clr_tick_o   (clr_tick),
    .scl_o        (scl_o),
    .sda_oe_o     (sda_oe_o),
    .busy_o       (busy_o),
    .state_o      (state_w),
    .shift_o      (shift),
    .hi_done_o    (hi_done),
    .lo_done_o    (lo_done),
    .ack_err_o    (ack_err_o)
  );

  aqm_rx_assemble #(.RES_W(RES_W)) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift),
    .hi_done_i (hi_done),
    .lo_done_i (lo_done),
    .bit_i     (sda_i),
    .hi_o      (high_byte_o),
    .lo_o      (low_byte_o),
    .result_o  (result_o),
    .valid_o   (result_valid_o)
  );

endmodule

// File: rtl/adc_poll_master_chk.sv
module adc_poll_master_chk
  import adc_poll_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       scl_o,
  input logic       sda_oe_o,
  input logic       result_valid_o,
  input logic       ack_err_o,
  input seq_state_e state_i
);

  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && !sda_oe_o && !result_valid_o)); // R1

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && (sda_oe_o != $past(sda_oe_o))) |->
      ($past(state_i) == ST_PRESTOP || $past(state_i) == ST_START ||
       $past(state_i) == ST_STOP)); // R3

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o); // R7

  AST_VALID_IN_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> busy_o); // R7

  AST_ACK_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |=> ack_err_o); // R8

  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R9

endmodule

bind adc_poll_master adc_poll_master_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .busy_o         (busy_o),
  .scl_o          (scl_o),
  .sda_oe_o       (sda_oe_o),
  .result_valid_o (result_valid_o),
  .ack_err_o      (ack_err_o),
  .state_i        (state_w)
);

// File: tb/test_adc_poll_master.sv
`timescale 1ns/1ps
module test_adc_poll_master;
  import adc_poll_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        cont_mode_i = 1'b0;
  logic [3:0]  conv_count_i = '0;
  logic [7:0]  div_i = 8'd1;
  wire         sda_line;
  logic        scl_o, sda_oe_o, busy_o, result_valid_o, ack_err_o;
  logic [11:0] result_o;
  logic [7:0]  high_byte_o, low_byte_o;

  int errors = 0;
  int checks = 0;

  // target model state
  int   n = 0;
  bit   active = 0, done = 0, present = 1;
  logic tgt_low = 1'b0;
  logic [7:0] addr_sh = '0;
  int   seed = 0, exp_conv = 1, got = 0;
  int   starts = 0, stops = 0, ack_bad = 0, addr_seen = 0;
  int   low_cnt = 0, low_bad = 0, low_seen = 0;

  always #4 clk = ~clk;

  assign sda_line = !(sda_oe_o || tgt_low);

  adc_poll_master i_adc_poll_master (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .cont_mode_i    (cont_mode_i),
    .conv_count_i   (conv_count_i),
    .div_i          (div_i),
    .sda_i          (sda_line),
    .scl_o          (scl_o),
    .sda_oe_o       (sda_oe_o),
    .busy_o         (busy_o),
    .result_o       (result_o),
    .high_byte_o    (high_byte_o),
    .low_byte_o     (low_byte_o),
    .result_valid_o (result_valid_o),
    .ack_err_o      (ack_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [11:0] tv(input int s, input int j);
    if (s == 1) return j[0] ? 12'hFFF : 12'h000;
    return 12'((s * 733 + j * 1373 + 291) % 4096);
  endfunction

  // bus conditions
  always @(negedge sda_line) if (scl_o) begin
    starts++; active = 1; done = 0; n = 0;
  end
  always @(posedge sda_line) if (scl_o) begin
    stops++; active = 0;
  end

  // master side bits seen by the target on SCL rise
  always @(posedge scl_o) begin
    if (active && !done) begin
      if (n < 8) begin
        addr_sh = {addr_sh[6:0], sda_line};
        if (n == 7) addr_seen = (addr_sh == 8'h9B) ? 1 : 2;
      end else if (n >= 9 && ((n - 9) % 9) == 8) begin
        automatic int f = (n - 9) / 9;
        if (f % 2 == 0) begin
          if (sda_line !== 1'b0) ack_bad++;           // R4 high byte ACK
        end else begin
          automatic logic expn = ((f / 2) == exp_conv - 1);
          if (sda_line !== expn) ack_bad++;           // R5 R6 low byte ACK/NACK
          if (sda_line) done = 1;
        end
      end
      n++;
    end
  end

  // target drives after SCL falls
  always @(negedge scl_o) begin
    tgt_low = 1'b0;
    if (active && !done && present) begin
      if (n == 8) tgt_low = 1'b1;
      else if (n >= 9) begin
        automatic int pos = (n - 9) % 9;
        automatic int f = (n - 9) / 9;
        automatic logic [11:0] v = tv(seed, f / 2);
        automatic logic [7:0] b = (f % 2 == 0) ? {4'b0, v[11:8]} : v[7:0];
        if (pos < 8) tgt_low = !b[7 - pos];
      end
    end
  end

  // result and SCL-low monitor
  always @(negedge clk) begin
    if (rst_ni && result_valid_o) begin
      automatic logic [11:0] v = tv(seed, got);
      check(result_o == v, "R7 result", result_o, v);
      check(high_byte_o == {4'b0, v[11:8]}, "R7 high byte", high_byte_o, v[11:8]);
      check(low_byte_o == v[7:0], "R7 low byte", low_byte_o, v[7:0]);
      got++;
    end
    if (!scl_o) low_cnt++;
    else if (low_cnt != 0) begin
      low_seen++;
      if (low_cnt != 2 * (int'(div_i) + 1)) low_bad++;
      low_cnt = 0;
    end
  end

  task automatic run_txn(input bit mode, input int cnt, input int dv, input bit pres,
                         input bit mid_start);
    int w;
    seed++;
    present = pres;
    exp_conv = !mode ? 1 : (cnt == 0 ? 3 : cnt);
    got = 0; starts = 0; stops = 0; ack_bad = 0; addr_seen = 0;
    low_bad = 0; low_seen = 0; low_cnt = 0;
    @(negedge clk);
    cont_mode_i = mode; conv_count_i = 4'(cnt); div_i = 8'(dv); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    if (mid_start) begin
      repeat (60) @(negedge clk);
      cont_mode_i = 1'b1; conv_count_i = 4'd4; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    w = 0;
    while (busy_o && w < 20000) begin
      @(negedge clk);
      w++;
    end
    check(!busy_o, "R9 transaction ends", busy_o, 0);
    check(scl_o && !sda_oe_o, "R1 lines released", {scl_o, sda_oe_o}, 2);
    check(starts == 1, "R2 one START", starts, 1);
    check(stops == 2, "R2 STOP before and after", stops, 2);
    check(addr_seen == 1, "R2 address 9B", addr_seen, 1);
    check(low_bad == 0 && low_seen > 0, "R3 SCL low width", low_bad, 0);
    if (pres) begin
      check(got == exp_conv, mode ? "R6 conversion count" : "R5 single conversion",
            got, exp_conv);
      check(ack_bad == 0, "R4 R5 R6 ACK/NACK pattern", ack_bad, 0);
    end else begin
      check(got == 0, "R8 no data after address NACK", got, 0);
      check(ack_err_o == 1'b1, "R8 error flag set", ack_err_o, 1);
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scl_o && !sda_oe_o && !busy_o && !result_valid_o && !ack_err_o,
          "R1 reset state", {scl_o, sda_oe_o, busy_o, result_valid_o, ack_err_o}, 16);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy_o && scl_o, "R1 idle after reset", busy_o, 0);

    check(calc_divider(20_000_000, 400_000) == 11, "R10 divider 400k",
          calc_divider(20_000_000, 400_000), 11);
    check(calc_divider(20_000_000, 100_000) == 49, "R10 divider 100k",
          calc_divider(20_000_000, 100_000), 49);

    for (int dv = 0; dv < 3; dv++) begin
      run_txn(1'b0, 5, dv, 1'b1, 1'b0);
      for (int c = 0; c < 5; c++) run_txn(1'b1, c, dv, 1'b1, 1'b0);
    end
    check(ack_err_o == 1'b0, "R8 no error with target present", ack_err_o, 0);

    run_txn(1'b1, 2, 1, 1'b0, 1'b0);
    run_txn(1'b0, 0, 1, 1'b1, 1'b0);
    check(ack_err_o == 1'b1, "R8 error flag sticky", ack_err_o, 1);

    run_txn(1'b0, 0, 1, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    check(!busy_o, "R9 start while busy ignored", busy_o, 0);

    rst_ni = 1'b0;
    @(negedge clk);
    check(!ack_err_o && scl_o && !sda_oe_o && !busy_o, "R1 reset clears error",
          ack_err_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule